// File: doc/BRIEF.md
# Debug Restart Sequencing Controller

This block sits between a test access port (TAP) controller and a processor core and decides when a halted core leaves debug state. It watches each instruction word scanned into the 34-bit instruction chain. The top bit of that word asks for the instruction to run at system speed. The block also watches the debug-clock pulses that execute scanned instructions, the instruction held in the TAP instruction register, and the TAP state. It keeps track of whether the core is in debug or system mode. It records that a system-speed access has happened, so the next chain capture can report it. It also flags system-speed requests on instruction classes that may not carry the flag.

Leaving debug state follows a fixed order:

1. The last system-speed instruction is scanned in with the flag set.
2. The closing branch is scanned in with the flag clear.
3. One debug-clock pulse loads the branch.
4. With the restart instruction in the TAP instruction register, restart becomes armed.
5. The core resumes on the transition into Run-Test-Idle.

Because resumption waits for that transition, several processors sharing one scan path can be released together.

Resumption is raised in the debug-clock domain as a toggle. A two-flop synchronizer carries it into the system-clock domain, where it becomes a one-cycle resume strobe. The system clock select is asserted together with that strobe.

Top module: `dbg_resume_ctrl`

## Requirements
- R1: After reset the block reports system mode (`dbg_mode`=0). `restart_armed`, `illegal_req`, `capture_flag` and `resume_pulse` are 0, and `clk_sel_sys` is 1.
- R2: A `halt_req` pulse in system mode sets `dbg_mode` at the next debug-clock edge. After synchronization, `clk_sel_sys` falls to 0, meaning the debug clock is selected.
- R3: On `instr_load`, `illegal_req` becomes 1 when bit 33 of `scan_word` is 1 and the opcode class in bits [27:25] is not 3'b010, 3'b011 or 3'b100. Otherwise it becomes 0. The value holds until the next `instr_load`.
- R4: A `dclk_pulse` in debug mode, while the loaded word has bit 33 set and a legal class, records a system-speed access. The next `capture` then drives `capture_flag` to 1, and the capture after that drives it to 0.
- R5: A branch counts as loaded only after three steps: a word with bit 33 set, then a word with bit 33 clear, then a `dclk_pulse`. Until the pulse arrives, restart cannot be armed.
- R6: `restart_armed` is set only while in debug mode with a loaded branch and `ir_code` equal to RESTART_CODE (default 4'b0100).
- R7: `restart_armed` clears at the next edge after `ir_code` differs from RESTART_CODE, or after `tap_state` is Test-Logic-Reset (4'hF).
- R8: Resumption happens only on a transition of `tap_state` into Run-Test-Idle (4'hC) while armed. At that point `dbg_mode` and `restart_armed` clear at the next edge. Arming while already in Run-Test-Idle does not resume.
- R9: Each resumption gives exactly one `resume_pulse` of one system-clock cycle. `clk_sel_sys` rises in the same cycle as that pulse and never without it.
- R10: A flagged word with an illegal class that is executed by `dclk_pulse` is not recorded as a system-speed access. The next `capture` gives `capture_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain reset, active low, asynchronous |
| tck | input | 1 | Debug/test clock |
| trst_n | input | 1 | Debug-domain reset, active low, asynchronous |
| halt_req | input | 1 | Core has entered debug state (one tck pulse) |
| instr_load | input | 1 | New instruction-chain word is valid (one tck pulse) |
| scan_word | input | CHAIN_W | Instruction-chain word; top bit is the system-speed flag |
| dclk_pulse | input | 1 | Debug clock pulse executing the loaded word |
| capture | input | 1 | Chain capture strobe |
| ir_code | input | IR_W | Current TAP instruction |
| tap_state | input | 4 | TAP state, IEEE 1149.1 encoding |
| dbg_mode | output | 1 | 1 = debug mode, 0 = system mode |
| restart_armed | output | 1 | Restart is armed |
| illegal_req | output | 1 | Flagged word has a disallowed opcode class |
| capture_flag | output | 1 | Flag bit reported by the last capture |
| resume_pulse | output | 1 | One-cycle resume strobe, system domain |
| clk_sel_sys | output | 1 | 1 = system clock selected |

## Verification
The bench arms restart while the TAP already sits in Run-Test-Idle. A design that tests the state level instead of the entry would resume at that point, too early. It loads the branch but withholds the debug-clock pulse, and a design that arms on the scan alone would arm there. It clears arming both by changing the instruction and by Test-Logic-Reset, and a design that ignores either would leave restart armed. It reads the capture flag twice, so a flag that is not cleared after the first read shows up. A scoreboard counts resume strobes, so a strobe that is doubled, stretched or missing is caught, as is a clock select that moves without a strobe.

// File: rtl/drs_pkg.sv
package drs_pkg;
    localparam logic [3:0] TAP_TLR = 4'hF;
    localparam logic [3:0] TAP_RTI = 4'hC;

    localparam logic [2:0] CLS_LDST_IMM = 3'b010;
    localparam logic [2:0] CLS_LDST_REG = 3'b011;
    localparam logic [2:0] CLS_BLOCK    = 3'b100;

    typedef struct packed {
        logic dbg_mode;
        logic cur_flag;
        logic cur_legal;
        logic branch_seen;
        logic branch_loaded;
        logic armed;
        logic sysspd_done;
        logic cap_bit;
        logic illegal;
        logic in_rti;
        logic resume_tgl;
    } dbg_st_t;

    typedef struct packed {
        logic [2:0] rsync;
        logic [2:0] msync;
        logic       pulse;
        logic       clk_sel;
    } sys_st_t;
endpackage

// File: rtl/drs_decode.sv
module drs_decode
    import drs_pkg::*;
(
    input  logic [2:0] opc_class,
    output logic       legal
);
    always_comb begin
        legal = (opc_class == CLS_LDST_IMM) ||
                (opc_class == CLS_LDST_REG) ||
                (opc_class == CLS_BLOCK);
    end
endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
    import drs_pkg::*;
#(
    parameter int               IR_W         = 4,
    parameter logic [IR_W-1:0]  RESTART_CODE = 4'b0100
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            halt_req,
    input  logic            instr_load,
    input  logic            word_flag,
    input  logic            word_legal,
    input  logic            dclk_pulse,
    input  logic            capture,
    input  logic [IR_W-1:0] ir_code,
    input  logic [3:0]      tap_state,
    output logic            dbg_mode,
    output logic            armed,
    output logic            illegal,
    output logic            cap_bit,
    output logic            resume_tgl
);
    dbg_st_t st_d, st_q;
    logic    rti_entry;
    logic    ir_restart;

    always_comb begin
        st_d       = st_q;
        ir_restart = (ir_code == RESTART_CODE);
        rti_entry  = (tap_state == TAP_RTI) && !st_q.in_rti;
        st_d.in_rti = (tap_state == TAP_RTI);

        if (halt_req && !st_q.dbg_mode) begin
            st_d.dbg_mode      = 1'b1;
            st_d.branch_seen   = 1'b0;
            st_d.branch_loaded = 1'b0;
        end

        if (capture && st_q.dbg_mode) begin
            st_d.cap_bit     = st_q.sysspd_done;
            st_d.sysspd_done = 1'b0;
        end

        if (dclk_pulse && st_q.dbg_mode) begin
            if (st_q.cur_flag && st_q.cur_legal) begin
                st_d.sysspd_done = 1'b1;
            end
            if (st_q.branch_seen) begin
                st_d.branch_loaded = 1'b1;
            end
        end

        if (instr_load) begin
            st_d.illegal       = word_flag && !word_legal;
            st_d.cur_flag      = word_flag;
            st_d.cur_legal     = word_legal;
            st_d.branch_seen   = !word_flag && st_q.cur_flag;
            st_d.branch_loaded = 1'b0;
        end

        if (st_q.dbg_mode && st_q.branch_loaded && ir_restart) begin
            st_d.armed = 1'b1;
        end
        if (!ir_restart || (tap_state == TAP_TLR) || !st_q.dbg_mode) begin
            st_d.armed = 1'b0;
        end

        if (st_q.armed && rti_entry) begin
            st_d.dbg_mode      = 1'b0;
            st_d.armed         = 1'b0;
            st_d.branch_seen   = 1'b0;
            st_d.branch_loaded = 1'b0;
            st_d.resume_tgl    = ~st_q.resume_tgl;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_mode   = st_q.dbg_mode;
    assign armed      = st_q.armed;
    assign illegal    = st_q.illegal;
    assign cap_bit    = st_q.cap_bit;
    assign resume_tgl = st_q.resume_tgl;
endmodule

// File: rtl/drs_sync.sv
module drs_sync
    import drs_pkg::*;
(
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic resume_tgl,
    input  logic dbg_mode,
    output logic resume_pulse,
    output logic clk_sel
);
    sys_st_t s_d, s_q;
    logic    resume_edge;
    logic    halt_edge;

    always_comb begin
        s_d         = s_q;
        s_d.rsync   = {s_q.rsync[1:0], resume_tgl};
        s_d.msync   = {s_q.msync[1:0], dbg_mode};
        resume_edge = s_q.rsync[1] ^ s_q.rsync[2];
        halt_edge   = s_q.msync[1] && !s_q.msync[2];
        s_d.pulse   = resume_edge;
        if (resume_edge) begin
            s_d.clk_sel = 1'b1;
        end else if (halt_edge) begin
            s_d.clk_sel = 1'b0;
        end
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            s_q         <= '0;
            s_q.clk_sel <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign resume_pulse = s_q.pulse;
    assign clk_sel      = s_q.clk_sel;
endmodule

// File: rtl/dbg_resume_ctrl.sv
module dbg_resume_ctrl
    import drs_pkg::*;
#(
    parameter int              CHAIN_W      = 34,
    parameter int              IR_W         = 4,
    parameter logic [IR_W-1:0] RESTART_CODE = 4'b0100
) (
    input  logic               sys_clk,
    input  logic               sys_rst_n,
    input  logic               tck,
    input  logic               trst_n,
    input  logic               halt_req,
    input  logic               instr_load,
    input  logic [CHAIN_W-1:0] scan_word,
    input  logic               dclk_pulse,
    input  logic               capture,
    input  logic [IR_W-1:0]    ir_code,
    input  logic [3:0]         tap_state,
    output logic               dbg_mode,
    output logic               restart_armed,
    output logic               illegal_req,
    output logic               capture_flag,
    output logic               resume_pulse,
    output logic               clk_sel_sys
);
    localparam int FLAG_BIT = CHAIN_W - 1;
    localparam int CLS_LSB  = 25;

    logic word_legal;
    logic resume_tgl;
    logic unused_bits;

    assign unused_bits = ^{scan_word[FLAG_BIT-1:CLS_LSB+3], scan_word[CLS_LSB-1:0]};

    drs_decode u_decode (
        .opc_class (scan_word[CLS_LSB+2:CLS_LSB]),
        .legal     (word_legal)
    );

    drs_ctrl #(
        .IR_W         (IR_W),
        .RESTART_CODE (RESTART_CODE)
    ) u_ctrl (
        .tck        (tck),
        .trst_n     (trst_n),
        .halt_req   (halt_req),
        .instr_load (instr_load),
        .word_flag  (scan_word[FLAG_BIT]),
        .word_legal (word_legal),
        .dclk_pulse (dclk_pulse),
        .capture    (capture),
        .ir_code    (ir_code),
        .tap_state  (tap_state),
        .dbg_mode   (dbg_mode),
        .armed      (restart_armed),
        .illegal    (illegal_req),
        .cap_bit    (capture_flag),
        .resume_tgl (resume_tgl)
    );

    drs_sync u_sync (
        .sys_clk      (sys_clk),
        .sys_rst_n    (sys_rst_n),
        .resume_tgl   (resume_tgl),
        .dbg_mode     (dbg_mode),
        .resume_pulse (resume_pulse),
        .clk_sel      (clk_sel_sys)
    );
endmodule

// File: rtl/drs_checker.sv
module drs_checker
    import drs_pkg::*;
#(
    parameter int              CHAIN_W      = 34,
    parameter int              IR_W         = 4,
    parameter logic [IR_W-1:0] RESTART_CODE = 4'b0100
) (
    input logic               sys_clk,
    input logic               sys_rst_n,
    input logic               tck,
    input logic               trst_n,
    input logic               instr_load,
    input logic [CHAIN_W-1:0] scan_word,
    input logic [IR_W-1:0]    ir_code,
    input logic [3:0]         tap_state,
    input logic               dbg_mode,
    input logic               restart_armed,
    input logic               illegal_req,
    input logic               resume_pulse,
    input logic               clk_sel_sys
);
    AST_ARM_NEEDS_RESTART: assert property (@(posedge tck) disable iff (!trst_n)
        restart_armed |-> ($past(ir_code) == RESTART_CODE && $past(dbg_mode))); // R6

    AST_TLR_DISARMS: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TAP_TLR) |=> !restart_armed); // R7

    AST_RTI_ENTRY_RESUMES: assert property (@(posedge tck) disable iff (!trst_n)
        (restart_armed && tap_state == TAP_RTI && $past(tap_state) != TAP_RTI)
        |=> (!dbg_mode && !restart_armed)); // R8

    AST_UNFLAGGED_LEGAL: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_load && !scan_word[CHAIN_W-1]) |=> !illegal_req); // R3

    AST_PULSE_ONE_CYCLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        resume_pulse |=> !resume_pulse); // R9

    AST_SEL_WITH_PULSE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(clk_sel_sys) |-> resume_pulse); // R9
endmodule

bind dbg_resume_ctrl drs_checker #(
    .CHAIN_W      (CHAIN_W),
    .IR_W         (IR_W),
    .RESTART_CODE (RESTART_CODE)
) u_drs_chk (
    .sys_clk       (sys_clk),
    .sys_rst_n     (sys_rst_n),
    .tck           (tck),
    .trst_n        (trst_n),
    .instr_load    (instr_load),
    .scan_word     (scan_word),
    .ir_code       (ir_code),
    .tap_state     (tap_state),
    .dbg_mode      (dbg_mode),
    .restart_armed (restart_armed),
    .illegal_req   (illegal_req),
    .resume_pulse  (resume_pulse),
    .clk_sel_sys   (clk_sel_sys)
);

// File: tb/test_dbg_resume_ctrl.sv
module test_dbg_resume_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TCK_PERIOD = 40;
    localparam logic [3:0] ST_TLR = 4'hF, ST_RTI = 4'hC, ST_SELDR = 4'h7, ST_UPDIR = 4'hD;
    localparam logic [3:0] IR_RESTART = 4'b0100, IR_OTHER = 4'b0010;

    logic sys_clk = 1'b0, tck = 1'b0;
    logic sys_rst_n = 1'b0, trst_n = 1'b0;
    logic halt_req = 1'b0, instr_load = 1'b0, dclk_pulse = 1'b0, capture = 1'b0;
    logic [33:0] scan_word = '0;
    logic [3:0]  ir_code = '0;
    logic [3:0]  tap_state = ST_TLR;
    logic dbg_mode, restart_armed, illegal_req, capture_flag, resume_pulse, clk_sel_sys;

    int n_cmp = 0, n_bad = 0;
    int exp_q[$];
    logic prev_pulse = 1'b0;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
    always #(TCK_PERIOD/2) tck = ~tck;

    dbg_resume_ctrl i_dbg_resume_ctrl (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .tck(tck), .trst_n(trst_n),
        .halt_req(halt_req), .instr_load(instr_load), .scan_word(scan_word),
        .dclk_pulse(dclk_pulse), .capture(capture), .ir_code(ir_code),
        .tap_state(tap_state), .dbg_mode(dbg_mode), .restart_armed(restart_armed),
        .illegal_req(illegal_req), .capture_flag(capture_flag),
        .resume_pulse(resume_pulse), .clk_sel_sys(clk_sel_sys)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge tck);
    endtask

    task automatic load_word(input logic flag, input logic [2:0] cls);
        scan_word = '0;
        scan_word[33] = flag;
        scan_word[27:25] = cls;
        scan_word[31:28] = 4'hE;
        instr_load = 1'b1;
        step();
        instr_load = 1'b0;
    endtask

    task automatic pulse_dclk();
        dclk_pulse = 1'b1; step(); dclk_pulse = 1'b0;
    endtask

    task automatic pulse_capture();
        capture = 1'b1; step(); capture = 1'b0;
    endtask

    task automatic expect_resume(input int id);
        exp_q.push_back(id);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops one expected resume per strobe seen
    always @(negedge sys_clk) begin
        if (sys_rst_n) begin
            if (resume_pulse) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R9: actual unexpected resume_pulse expected none");
                end else begin
                    void'(exp_q.pop_front());
                end
                chk("R9 clk_sel with pulse", int'(clk_sel_sys), 1);
                if (prev_pulse) chk("R9 pulse width", 2, 1);
            end
            prev_pulse = resume_pulse;
        end
    end

    initial begin
        repeat (50000) @(posedge sys_clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(2);
        trst_n = 1'b1; sys_rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 dbg_mode", int'(dbg_mode), 0);
        chk("R1 armed", int'(restart_armed), 0);
        chk("R1 illegal", int'(illegal_req), 0);
        chk("R1 capture_flag", int'(capture_flag), 0);
        chk("R1 clk_sel", int'(clk_sel_sys), 1);
        chk("R1 resume_pulse", int'(resume_pulse), 0);

        tap_state = ST_UPDIR;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R2 dbg_mode after halt", int'(dbg_mode), 1);
        step(2);
        chk("R2 clk_sel to debug", int'(clk_sel_sys), 0);

        // R3 class checks
        load_word(1'b1, 3'b000);
        chk("R3 flagged data-proc illegal", int'(illegal_req), 1);
        load_word(1'b0, 3'b000);
        chk("R3 unflagged legal", int'(illegal_req), 0);
        load_word(1'b1, 3'b011);
        chk("R3 flagged load/store legal", int'(illegal_req), 0);

        // R4 capture flag after system-speed access
        pulse_dclk();
        pulse_capture();
        chk("R4 first capture", int'(capture_flag), 1);
        pulse_capture();
        chk("R4 second capture", int'(capture_flag), 0);

        // R10 illegal flagged not recorded
        load_word(1'b1, 3'b001);
        pulse_dclk();
        pulse_capture();
        chk("R10 capture after illegal", int'(capture_flag), 0);

        // R5 branch needs dclk pulse
        load_word(1'b1, 3'b100);
        pulse_dclk();
        load_word(1'b0, 3'b101);
        ir_code = IR_RESTART;
        step(2);
        chk("R5 no arm without dclk", int'(restart_armed), 0);
        pulse_dclk();
        step();
        chk("R6 armed with RESTART", int'(restart_armed), 1);

        // R7 disarm by IR change and TLR
        ir_code = IR_OTHER; step();
        chk("R7 disarm on IR change", int'(restart_armed), 0);
        step();
        chk("R6 no arm without RESTART", int'(restart_armed), 0);
        ir_code = IR_RESTART; step(2);
        tap_state = ST_TLR; step();
        chk("R7 disarm on TLR", int'(restart_armed), 0);

        // R8 arming while already in RTI must not resume
        tap_state = ST_RTI; ir_code = IR_OTHER; step(2);
        ir_code = IR_RESTART; step(3);
        chk("R8 armed inside RTI", int'(restart_armed), 1);
        chk("R8 no resume without entry", int'(dbg_mode), 1);
        chk("R8 clk_sel still debug", int'(clk_sel_sys), 0);

        tap_state = ST_SELDR; step();
        expect_resume(1);
        tap_state = ST_RTI; step();
        chk("R8 dbg_mode cleared", int'(dbg_mode), 0);
        chk("R8 armed cleared", int'(restart_armed), 0);
        step(4);
        chk("R9 clk_sel system", int'(clk_sel_sys), 1);
        chk("R9 resume strobes seen", exp_q.size(), 0);
        step(4);
        finish_run();
    end
endmodule